// File: doc/BRIEF.md
# Bus Address Window Translator

This block decides whether a bus address falls inside one of three programmable address windows and, when it does, rebases the address into another address space. Two windows face outward from the local system: one for memory requests and one for IO requests. Each of these turns a local address into an address on the PCI-style bus. The third window faces inward. It works like a base address register: PCI memory addresses that land in it are moved into local memory.

Each window holds three values. The match base sets where the window sits. The target base sets where hits are moved to. A 3-bit size code sets the window size, which is one of six powers of two from 256KB to 256MB. The inbound window also has an enable bit. Software programs these values through a simple write port. Lookups use a request/response path: each request returns a registered response one clock later. The response carries a hit flag, the identity of the window that hit and the translated address.

Top module: `addr_xlat`

## Requirements
- R1: After reset `rsp_valid` is low and every window is disabled, so every lookup misses until software programs a window.
- R2: Size code c in 0..5 gives a window of 2^(28-2c) bytes: 256MB, 64MB, 16MB, 4MB, 1MB and 256KB. Codes 6 and 7 disable the window, so it never hits.
- R3: A request hits a window when the address bits at and above log2(size) equal the same bits of the match base. The translated address takes those upper bits from the target base and keeps the request's offset bits below log2(size).
- R4: Bits of the match base and of the target base below log2(size) have no effect on hit or on the translated address.
- R5: Only one window is checked for each request type. An outbound memory request (`req_dir`=0, `req_is_io`=0) checks only the memory window. An outbound IO request (`req_dir`=0, `req_is_io`=1) checks only the IO window. An inbound memory request (`req_dir`=1, `req_is_io`=0) checks only the inbound window. An inbound IO request always misses.
- R6: The inbound window hits only while bit 3 of its control register is set.
- R7: A request accepted on one clock edge gives `rsp_valid`=1 on the next edge. `rsp_valid` is 0 on edges with no request. A miss returns `rsp_hit`=0, `rsp_win`=0 and `rsp_addr`=0. A hit sets `rsp_win` to 1 for the memory window, 2 for the IO window and 3 for the inbound window.
- R8: A register write changes lookups from the next cycle on. A request made in the same cycle as the write sees the old value. `wr_addr[3:2]` selects the window: 0 is memory, 1 is IO, 2 is inbound and 3 selects nothing. `wr_addr[1:0]` selects the field: 0 is the match base, 1 is the target base and 2 is control. Control holds the size code in bits [2:0] and the inbound enable in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Window select [3:2] and field select [1:0] |
| wr_data | input | ADDR_W | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_dir | input | 1 | 0 = outbound, 1 = inbound |
| req_is_io | input | 1 | 1 = IO request, 0 = memory request |
| req_addr | input | ADDR_W | Address to look up |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Window hit |
| rsp_win | output | 2 | Window that hit: 0 none, 1 memory, 2 IO, 3 inbound |
| rsp_addr | output | ADDR_W | Translated address, 0 on a miss |

## Verification
The window registers and the response register are the only state in the block. A corrupted base, target or size code therefore shows up on the very next response that uses that window, one clock after the request. It can appear as a wrong hit flag at the window boundaries or as wrong upper bits in `rsp_addr`. The bench checks every size code of every window at the first and last address inside the window and at the addresses just outside it, and it tries all three request types at each address. A wrong mask width, a failed write or a type mix-up is therefore seen on the first lookup made after the bad state appears.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_OMEM = 2'd1,
    WIN_OIO  = 2'd2,
    WIN_IN   = 2'd3
  } win_id_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_TGT  = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_RSVD = 2'd3
  } fld_e;

  localparam int NUM_WIN     = 3;
  localparam int SIZE_CODES  = 6;
  localparam int CTRL_EN_BIT = 3;
  localparam int CODE_W      = 3;

endpackage

// File: rtl/xlat_window.sv
module xlat_window
  import addr_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned LOG2_LARGEST = 28,
  parameter bit          NEEDS_EN     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_fld,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              sel,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);

  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(SIZE_CODES - 1);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [CODE_W-1:0] code_q;
  logic              en_q;
  logic [ADDR_W-1:0] mask;
  logic              code_ok;
  logic              en_eff;
  int unsigned       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      tgt_q  <= '0;
      code_q <= '1;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (fld_e'(wr_fld))
        FLD_BASE: base_q <= wr_data;
        FLD_TGT:  tgt_q  <= wr_data;
        FLD_CTRL: begin
          code_q <= wr_data[CODE_W-1:0];
          en_q   <= wr_data[CTRL_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  // Size code c selects 2^(LOG2_LARGEST - 2c) bytes
  always_comb begin
    code_ok = (code_q <= LAST_CODE);
    sh      = LOG2_LARGEST - 2 * 32'(code_q);
    mask    = code_ok ? ({ADDR_W{1'b1}} << sh) : '0;
    en_eff  = NEEDS_EN ? en_q : 1'b1;
    hit     = sel && code_ok && en_eff && ((lk_addr & mask) == (base_q & mask));
    xaddr   = (tgt_q & mask) | (lk_addr & ~mask);
  end

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_fld == FLD_CTRL) && !$past(rst)) |-> (code_q == $past(wr_data[CODE_W-1:0]))); // R8

  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    hit |-> (((xaddr ^ lk_addr) & ~mask) == '0)); // R3

  generate
    if (NEEDS_EN) begin : g_en_chk
      AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        hit |-> en_q); // R6
    end
  endgenerate

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import addr_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NWIN   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [NWIN-1:0]             hit_vec,
  input  logic [NWIN-1:0][ADDR_W-1:0] xaddr_vec,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic [1:0]                  rsp_win,
  output logic [ADDR_W-1:0]           rsp_addr
);

  logic              any_hit;
  logic [1:0]        win_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    any_hit = 1'b0;
    win_d   = WIN_NONE;
    addr_d  = '0;
    for (int i = 0; i < int'(NWIN); i++) begin
      if (hit_vec[i] && !any_hit) begin
        any_hit = 1'b1;
        win_d   = 2'(i + 1);
        addr_d  = xaddr_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= WIN_NONE;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_win   <= (req_valid && any_hit) ? win_d : WIN_NONE;
      rsp_addr  <= (req_valid && any_hit) ? addr_d : '0;
    end
  end

  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_win == WIN_NONE && rsp_addr == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit); // R7

endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
  import addr_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned LOG2_LARGEST = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic              req_dir,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_win,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int unsigned SMALLEST_LOG2 = LOG2_LARGEST - 2 * (SIZE_CODES - 1);

  logic [NUM_WIN-1:0]             sel_vec;
  logic [NUM_WIN-1:0]             hit_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr_vec;

  // One window per request type: outbound memory, outbound IO, inbound memory
  assign sel_vec[0] = !req_dir && !req_is_io;
  assign sel_vec[1] = !req_dir &&  req_is_io;
  assign sel_vec[2] =  req_dir && !req_is_io;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      xlat_window #(
        .ADDR_W       (ADDR_W),
        .LOG2_LARGEST (LOG2_LARGEST),
        .NEEDS_EN     (w == 2)
      ) u_win (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && (wr_addr[3:2] == 2'(w))),
        .wr_fld  (wr_addr[1:0]),
        .wr_data (wr_data),
        .sel     (sel_vec[w]),
        .lk_addr (req_addr),
        .hit     (hit_vec[w]),
        .xaddr   (xaddr_vec[w])
      );
    end
  endgenerate

  xlat_pick #(
    .ADDR_W (ADDR_W),
    .NWIN   (NUM_WIN)
  ) u_pick (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .hit_vec   (hit_vec),
    .xaddr_vec (xaddr_vec),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr)
  );

  initial begin
    AST_PARAM_FITS: assert (LOG2_LARGEST < ADDR_W && SMALLEST_LOG2 > 0); // R2
  end

  AST_ONE_WINDOW_TYPE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R5

  AST_INBOUND_IO_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_dir && req_is_io)) |-> !rsp_hit); // R5

endmodule

// File: tb/addr_xlat_tb.sv
module addr_xlat_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_dir = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_base [3];
  logic [31:0] m_tgt  [3];
  int          m_code [3];
  logic        m_en;

  always #5 clk = ~clk;

  addr_xlat u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_dir(req_dir), .req_is_io(req_is_io), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  function automatic void model(input logic dir, input logic io, input logic [31:0] a,
                                output logic eh, output logic [1:0] ew, output logic [31:0] ea);
    int w;
    logic [31:0] sz, mask;
    eh = 1'b0; ew = 2'd0; ea = 32'd0;
    if (dir && io) return;
    w = dir ? 2 : (io ? 1 : 0);
    if (m_code[w] > 5) return;
    if (w == 2 && !m_en) return;
    sz   = 32'd1 << (28 - 2 * m_code[w]);
    mask = ~(sz - 32'd1);
    if ((a & mask) == (m_base[w] & mask)) begin
      eh = 1'b1;
      ew = 2'(w + 1);
      ea = (m_tgt[w] & mask) | (a & ~mask);
    end
  endfunction

  task automatic check_rsp(input string tag, input logic eh, input logic [1:0] ew, input logic [31:0] ea);
    n_chk++;
    if (!(rsp_valid === 1'b1 && rsp_hit === eh && rsp_win === ew && rsp_addr === ea)) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b hit=%0b win=%0d addr=%h, expected valid=1 hit=%0b win=%0d addr=%h",
               tag, rsp_valid, rsp_hit, rsp_win, rsp_addr, eh, ew, ea);
    end
  endtask

  task automatic write_reg(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {2'(w), 2'(f)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (f == 0) m_base[w] = d;
    else if (f == 1) m_tgt[w] = d;
    else begin
      m_code[w] = int'(d[2:0]);
      if (w == 2) m_en = d[3];
    end
  endtask

  task automatic lookup(input logic dir, input logic io, input logic [31:0] a, input string tag);
    logic eh; logic [1:0] ew; logic [31:0] ea;
    model(dir, io, a, eh, ew, ea);
    @(negedge clk);
    req_valid = 1'b1; req_dir = dir; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, eh, ew, ea);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_tgt[i] = '0; m_code[i] = 7; end
    m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: got rsp_valid=%0b, expected 0", rsp_valid);
    end
    lookup(1'b0, 1'b0, 32'h0000_0000, "R1");
    lookup(1'b0, 1'b1, 32'h0000_0000, "R1");
    lookup(1'b1, 1'b0, 32'h0000_0000, "R1");

    // R7: no request, no response
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      n_fail++; $display("FAIL R7: got valid=%0b hit=%0b, expected 0 0", rsp_valid, rsp_hit);
    end

    // Bases and targets carry junk low bits
    write_reg(0, 0, 32'h8123_4567); write_reg(0, 1, 32'hF0AB_CDEF);
    write_reg(1, 0, 32'hA000_0FFF); write_reg(1, 1, 32'h2000_0003);
    write_reg(2, 0, 32'h1000_0ABC); write_reg(2, 1, 32'h3000_0000);

    // R4: 256MB memory window ignores the junk low bits
    write_reg(0, 2, 32'd0);
    lookup(1'b0, 1'b0, 32'h8000_0000, "R4");
    lookup(1'b0, 1'b0, 32'h8765_4321, "R4");

    // R6: inbound window disabled, then enabled
    write_reg(2, 2, 32'h0000_0000);
    lookup(1'b1, 1'b0, 32'h1000_0000, "R6");
    write_reg(2, 2, 32'h0000_0008);
    lookup(1'b1, 1'b0, 32'h1000_0000, "R6");
    lookup(1'b1, 1'b1, 32'h1000_0000, "R5");

    // R2/R3/R5 sweep over all codes of all windows
    for (int w = 0; w < 3; w++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] b, sz, mask;
        logic [31:0] pts [7];
        write_reg(w, 2, 32'(c) | (w == 2 ? 32'h8 : 32'h0));
        sz   = (c <= 5) ? (32'd1 << (28 - 2 * c)) : 32'h0004_0000;
        mask = ~(sz - 32'd1);
        b    = m_base[w] & mask;
        pts[0] = b; pts[1] = b + sz - 32'd1; pts[2] = b + sz; pts[3] = b - 32'd1;
        pts[4] = b + (sz >> 1) + 32'h44; pts[5] = 32'h0; pts[6] = 32'hFFFF_FFFC;
        for (int p = 0; p < 7; p++) begin
          for (int t = 0; t < 3; t++) begin
            string tag;
            tag = (t != w) ? "R5" : ((c > 5) ? "R2" : "R3");
            lookup(t == 2, t == 1, pts[p], tag);
          end
        end
      end
    end

    // R8: a write and a request in the same cycle see the old base
    write_reg(0, 2, 32'd0);
    write_reg(0, 0, 32'h8000_0000);
    begin
      logic eh; logic [1:0] ew; logic [31:0] ea;
      model(1'b0, 1'b0, 32'h8000_0010, eh, ew, ea);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'b0000; wr_data = 32'h4000_0000;
      req_valid = 1'b1; req_dir = 1'b0; req_is_io = 1'b0; req_addr = 32'h8000_0010;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      m_base[0] = 32'h4000_0000;
      check_rsp("R8", eh, ew, ea);
    end
    lookup(1'b0, 1'b0, 32'h8000_0010, "R8");
    lookup(1'b0, 1'b0, 32'h4000_0010, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule